// File: doc/BRIEF.md
# Token Readout Delay Controller

This block runs one readout of a double-sided strip detector module. A readout starts on the rising edge of the token input, which is sampled on the rising edge of the readout clock. The first detector side gets the token straight away. The second side gets a one-cycle token pulse after a delay that can be programmed in whole blocks of clock cycles. All token and window outputs are launched on the falling clock edge, so the front-end chips see them half a cycle after the rising edge that produced them.

During the readout the block drives two outputs. A buffer-enable window is held high for the whole readout, and a side-select level marks when the second side is being read. At one expected clock edge, the block checks that the token comes back from the far hybrid. A missing return or a return at the wrong time sets a sticky error flag. An active-low fast-clear aborts the readout that is in progress. A bypass setting turns the block into a plain wire for the token, for positions where it only buffers signals. The delay enable, the bypass bit and the two chip counts arrive on plain input ports.

Two values fix the timing of a readout. STEP is the number of clock cycles per chip, 128 by default. The rising edge at which the token is sampled is edge k0. The second-side token fires at D = 2 + (delayEn ? readChips·STEP : 0) cycles after edge k0. The readout closes at E = D + waitChips·STEP cycles after edge k0.

Top module: `readout_token_sequencer`

## Requirements
- R1: `tokenIn` is sampled on the rising clock edge. `tokenOutA` copies the sampled value at the next falling edge. It therefore stays low at the rising edge where the token is sampled and is high one cycle later.
- R2: With `delayEn` = 0, `tokenOutB` is a single-cycle pulse that starts at the falling edge after rising edge k0+2.
- R3: With `delayEn` = 1, the `tokenOutB` pulse starts at the falling edge after rising edge k0+2+readChips·STEP. With `readChips` = 0 the timing is the same as with the delay disabled.
- R4: `bufEn` goes high at the falling edge after edge k0 and stays high for exactly E cycles.
- R5: `sideSel` goes high together with the second-side token and falls together with `bufEn`, so it is high for E−D cycles. If `waitChips` = 0, it never goes high.
- R6: The returned token `tokenRet` must be high at rising edge k0+E and low at every other rising edge of the readout. A missing return or a return at the wrong time sets `tokenErr`, at most once per readout.
- R7: `tokenErr` stays set until a rising edge at which `errClr` is high.
- R8: A low level on `fastClrN` at a rising edge ends the readout. No second-side token is sent, and `bufEn` and `sideSel` drop. `tokenErr` and the settings are not changed. Once `fastClrN` is high again, a new readout runs normally.
- R9: With `bypass` = 1, both token outputs follow `tokenIn` combinationally, and no readout starts.
- R10: A new rise of `tokenIn` during a running readout is ignored. It adds no second-side token and does not lengthen the window.
- R11: While `rstN` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tokenIn | input | 1 | Incoming readout token |
| tokenRet | input | 1 | Token returned by the far hybrid |
| fastClrN | input | 1 | Readout abort, active low |
| errClr | input | 1 | Clears the token error flag |
| delayEn | input | 1 | Enables the programmed inter-side delay |
| bypass | input | 1 | Wires the token input straight to both token outputs |
| waitChips | input | CHIP_W | Chip count read on the far side before the token returns |
| readChips | input | CHIP_W | Chip count that sets the inter-side delay in STEP blocks |
| tokenOutA | output | 1 | Token to the first detector side |
| tokenOutB | output | 1 | Delayed token to the second detector side |
| bufEn | output | 1 | Buffer enable for the readout window |
| sideSel | output | 1 | High while the second side is read |
| tokenErr | output | 1 | Sticky token-return error |

## Verification
The assertions take for granted that `delayEn`, `readChips` and `waitChips` stay unchanged while a readout is running. The counter bound and the window checks are only valid under that condition. The stimulus changes these settings only between readouts, when the block is idle. It toggles `bypass` only while no readout is in flight. Every input is driven just after a falling edge, so it is stable well before the next rising edge where it is sampled.

// File: rtl/tokdly_pkg.sv
package tokdly_pkg;

  // control -> datapath strobes and levels
  typedef struct packed {
    logic start;   // readout begins this edge
    logic clear;   // abort or bypass: drop everything in flight
    logic run;     // readout counter advances
    logic fireB;   // second-side token due this edge
    logic bufOn;   // readout window level
    logic selOn;   // second side being read
  } ctlStrobe_t;

endpackage

// File: rtl/tokdly_ctrl.sv
module tokdly_ctrl
  import tokdly_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokenIn,
  input  logic       tokenRet,
  input  logic       fastClrN,
  input  logic       errClr,
  input  logic       bypass,
  input  logic       atD,
  input  logic       atE,
  output ctlStrobe_t st,
  output logic       tokenErr
);

  logic tokPrev, activeQ, selQ, errSeen;
  logic clrNow, startNow, endNow, missHit, errNow;

  always_comb begin
    clrNow   = !fastClrN || bypass;
    startNow = tokenIn && !tokPrev && !activeQ && !clrNow;
    endNow   = activeQ && atE && !clrNow;
    // return must coincide exactly with the closing edge
    missHit  = activeQ && !clrNow && (tokenRet != atE);
    errNow   = missHit && !errSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokPrev  <= 1'b0;
      activeQ  <= 1'b0;
      selQ     <= 1'b0;
      errSeen  <= 1'b0;
      tokenErr <= 1'b0;
    end else begin
      tokPrev <= tokenIn;

      if (clrNow)        activeQ <= 1'b0;
      else if (startNow) activeQ <= 1'b1;
      else if (endNow)   activeQ <= 1'b0;

      if (clrNow || endNow)       selQ <= 1'b0;
      else if (activeQ && atD)    selQ <= 1'b1;

      if (startNow)    errSeen <= 1'b0;
      else if (errNow) errSeen <= 1'b1;

      if (errNow)      tokenErr <= 1'b1;
      else if (errClr) tokenErr <= 1'b0;
    end
  end

  always_comb begin
    st.start = startNow;
    st.clear = clrNow;
    st.run   = activeQ && !clrNow;
    st.fireB = activeQ && atD && !clrNow;
    st.bufOn = activeQ;
    st.selOn = selQ;
  end

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokenErr && !errClr) |=> tokenErr);

  // R8
  fastclr_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fastClrN |=> !activeQ);

  // R5
  sel_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    selQ |-> activeQ);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !atE && fastClrN && !bypass) |=> activeQ);

endmodule

// File: rtl/tokdly_dp.sv
module tokdly_dp
  import tokdly_pkg::*;
#(
  parameter int STEP   = 128,
  parameter int CHIP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokenIn,
  input  logic              delayEn,
  input  logic [CHIP_W-1:0] readChips,
  input  logic [CHIP_W-1:0] waitChips,
  input  ctlStrobe_t        st,
  output logic              atD,
  output logic              atE,
  output logic              tokOutA,
  output logic              tokOutB,
  output logic              bufEn,
  output logic              sideSel
);

  localparam int CHIP_MAX = (1 << CHIP_W) - 1;
  localparam int MAX_E    = 2 + 2 * CHIP_MAX * STEP;
  localparam int CNT_W    = $clog2(MAX_E + 1);

  logic [CNT_W-1:0] cnt, dLim, eLim, stepW;
  logic aQ, bQ;

  always_comb begin
    stepW = CNT_W'(STEP);
    dLim  = CNT_W'(2) + (delayEn ? CNT_W'(readChips) * stepW : '0);
    eLim  = dLim + CNT_W'(waitChips) * stepW;
    atD   = (cnt == dLim);
    atE   = (cnt == eLim);
  end

  // rising-edge domain: counter and token sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      aQ  <= 1'b0;
      bQ  <= 1'b0;
    end else begin
      if (st.clear)      cnt <= '0;
      else if (st.start) cnt <= CNT_W'(1);
      else if (st.run)   cnt <= cnt + CNT_W'(1);
      aQ <= st.clear ? 1'b0 : tokenIn;
      bQ <= st.fireB;
    end
  end

  // falling-edge launch of everything the front end sees
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      tokOutA <= 1'b0;
      tokOutB <= 1'b0;
      bufEn   <= 1'b0;
      sideSel <= 1'b0;
    end else begin
      tokOutA <= aQ;
      tokOutB <= bQ;
      bufEn   <= st.bufOn;
      sideSel <= st.selOn;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.run |-> (cnt <= eLim));

  // R2
  b_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bQ |=> !bQ);

endmodule

// File: rtl/readout_token_sequencer.sv
module readout_token_sequencer
  import tokdly_pkg::*;
#(
  parameter int STEP   = 128,
  parameter int CHIP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokenIn,
  input  logic              tokenRet,
  input  logic              fastClrN,
  input  logic              errClr,
  input  logic              delayEn,
  input  logic              bypass,
  input  logic [CHIP_W-1:0] waitChips,
  input  logic [CHIP_W-1:0] readChips,
  output logic              tokenOutA,
  output logic              tokenOutB,
  output logic              bufEn,
  output logic              sideSel,
  output logic              tokenErr
);

  ctlStrobe_t st;
  logic atD, atE, tokA, tokB;

  tokdly_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tokenIn  (tokenIn),
    .tokenRet (tokenRet),
    .fastClrN (fastClrN),
    .errClr   (errClr),
    .bypass   (bypass),
    .atD      (atD),
    .atE      (atE),
    .st       (st),
    .tokenErr (tokenErr)
  );

  tokdly_dp #(.STEP(STEP), .CHIP_W(CHIP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tokenIn   (tokenIn),
    .delayEn   (delayEn),
    .readChips (readChips),
    .waitChips (waitChips),
    .st        (st),
    .atD       (atD),
    .atE       (atE),
    .tokOutA   (tokA),
    .tokOutB   (tokB),
    .bufEn     (bufEn),
    .sideSel   (sideSel)
  );

  assign tokenOutA = bypass ? tokenIn : tokA;
  assign tokenOutB = bypass ? tokenIn : tokB;

endmodule

// File: tb/readout_token_sequencer_bench.sv
module readout_token_sequencer_bench;

  localparam int STEP   = 128;
  localparam int CHIP_W = 3;

  logic clk = 1'b0, rstN = 1'b0, tokenIn = 1'b0, tokenRet = 1'b0;
  logic fastClrN = 1'b1, errClr = 1'b0, delayEn = 1'b0, bypass = 1'b0;
  logic [CHIP_W-1:0] waitChips = '0, readChips = '0;
  logic tokenOutA, tokenOutB, bufEn, sideSel, tokenErr;

  int cyc = 0, total = 0, bad = 0;
  int expQ[$];
  bit done = 1'b0;

  readout_token_sequencer #(.STEP(STEP), .CHIP_W(CHIP_W)) u_readout_token_sequencer (
    .clk(clk), .rstN(rstN), .tokenIn(tokenIn), .tokenRet(tokenRet),
    .fastClrN(fastClrN), .errClr(errClr), .delayEn(delayEn), .bypass(bypass),
    .waitChips(waitChips), .readChips(readChips),
    .tokenOutA(tokenOutA), .tokenOutB(tokenOutB), .bufEn(bufEn),
    .sideSel(sideSel), .tokenErr(tokenErr)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every second-side pulse must match a queued cycle
  always @(posedge clk) begin
    int e;
    #2;
    if (rstN && !bypass && tokenOutB) begin
      if (expQ.size() == 0) chk(1'b0, "R3 unexpected second-side token", cyc, -1);
      else begin
        e = expQ.pop_front();
        chk(cyc == e, "R3 second-side token cycle", cyc, e);
      end
    end
  end

  // retMode: 0 on time, 1 missing, 2 one cycle early
  task automatic readout(input bit en, input int rd, input int wt,
                         input int retMode, input bit extraTok);
    int dl, el, k0, retEdge, bufCnt, selCnt, c;
    dl = 2 + (en ? rd * STEP : 0);
    el = dl + wt * STEP;
    delayEn   = en;
    readChips = CHIP_W'(rd);
    waitChips = CHIP_W'(wt);
    @(negedge clk); #2;
    tokenIn = 1'b1;
    k0 = cyc + 1;
    expQ.push_back(k0 + dl + 1);
    retEdge = (retMode == 0) ? k0 + el : (retMode == 2) ? k0 + el - 1 : -10;
    bufCnt = 0;
    selCnt = 0;
    do begin
      @(posedge clk); #2;
      c = cyc;
      if (bufEn) bufCnt++;
      if (sideSel) selCnt++;
      if (c == k0) chk(tokenOutA == 1'b0, "R1 first-side output waits for falling edge", tokenOutA, 0);
      if (c == k0 + 1) chk(tokenOutA == 1'b1, "R1 first-side token", tokenOutA, 1);
      if (c == k0 + dl + 1)
        chk(tokenOutB == 1'b1, en ? "R3 delayed second-side token" : "R2 fixed two-cycle token",
            tokenOutB, 1);
      @(negedge clk); #2;
      tokenIn  = extraTok && (c == k0 + 5);   // R10 stray rise mid-readout
      tokenRet = (cyc + 1 == retEdge);
    end while (c < k0 + el + 2);
    tokenRet = 1'b0;
    tokenIn  = 1'b0;
    chk(bufCnt == el, "R4 buffer window length", bufCnt, el);
    chk(selCnt == el - dl, "R5 side-select length", selCnt, el - dl);
    chk(tokenErr == (retMode != 0), "R6 return check result", tokenErr, int'(retMode != 0));
  endtask

  task automatic clearErr();
    repeat (3) @(posedge clk);
    #2;
    chk(tokenErr == 1'b1, "R7 error stays latched", tokenErr, 1);
    @(negedge clk); #2; errClr = 1'b1;
    @(negedge clk); #2; errClr = 1'b0;
    @(posedge clk); #2;
    chk(tokenErr == 1'b0, "R7 error cleared", tokenErr, 0);
  endtask

  task automatic fastClearRun();
    int bufHigh;
    delayEn = 1'b1; readChips = 1; waitChips = 1;
    @(negedge clk); #2; tokenIn = 1'b1;
    @(negedge clk); #2; tokenIn = 1'b0;
    repeat (20) @(negedge clk);
    #2; fastClrN = 1'b0;
    @(negedge clk); #2; fastClrN = 1'b1;
    bufHigh = 0;
    repeat (300) begin
      @(posedge clk); #2;
      if (bufEn || sideSel) bufHigh++;
    end
    chk(bufHigh == 0, "R8 window dropped after fast-clear", bufHigh, 0);
    chk(tokenErr == 1'b0, "R8 error flag untouched by fast-clear", tokenErr, 0);
  endtask

  task automatic bypassRun();
    @(negedge clk); #2;
    bypass = 1'b1;
    tokenIn = 1'b1;
    #1;
    chk(tokenOutA && tokenOutB, "R9 bypass passes token high", int'(tokenOutA && tokenOutB), 1);
    @(posedge clk); #2;
    chk(bufEn == 1'b0, "R9 no readout in bypass", bufEn, 0);
    tokenIn = 1'b0;
    #1;
    chk(!tokenOutA && !tokenOutB, "R9 bypass passes token low", int'(tokenOutA || tokenOutB), 0);
    @(negedge clk); #2; bypass = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk({tokenOutA, tokenOutB, bufEn, sideSel, tokenErr} == 5'b0, "R11 outputs low in reset",
        {tokenOutA, tokenOutB, bufEn, sideSel, tokenErr}, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);

    readout(1'b0, 6, 1, 0, 1'b0);   // delay off
    readout(1'b1, 6, 6, 0, 1'b0);   // default counts
    readout(1'b1, 0, 2, 0, 1'b0);   // zero chips equals delay off
    readout(1'b1, 7, 7, 0, 1'b1);   // maximum, stray token
    readout(1'b0, 3, 0, 0, 1'b0);   // no far-side wait
    readout(1'b1, 1, 1, 1, 1'b0);   // missing return
    clearErr();
    readout(1'b1, 1, 2, 2, 1'b0);   // early return
    clearErr();
    fastClearRun();
    readout(1'b1, 2, 1, 0, 1'b0);   // R8 normal after abort
    bypassRun();
    readout(1'b0, 0, 1, 0, 1'b0);

    repeat (4) @(posedge clk);
    chk(expQ.size() == 0, "R3 every queued second-side token seen", expQ.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule